// File: doc/BRIEF.md
# Micro-TLB Pair with Lazy Invalidation

This block holds two small fully associative translation caches that sit in front of a larger joint TLB: an 8-entry one serving data accesses and a 4-entry one serving instruction fetches. Each cache answers a lookup in the same cycle it is presented. A lookup matches on the virtual page number and an 8-bit address-space ID, and entries marked global skip the ID comparison. On a miss, the cache stalls the requester and asks the joint TLB for the entry over a valid/ready request channel. The answer arrives on a response strobe and is installed in a slot picked by a round-robin pointer.

Invalidation is lazy. When the joint TLB overwrites one of its own entries with a write flagged as keep, for example to replace a victim during miss handling, both micro caches keep everything they hold. Their higher associativity then hides conflict misses in the joint TLB. A joint-TLB write without the keep flag clears both caches, and so does a dedicated invalidate strobe, which acts even when no joint-TLB write takes place. Permission bits are not checked here. They are stored and passed through unchanged.

The request channel follows valid/ready rules. `*_req_valid` rises in the cycle of the missing lookup and stays high with a stable key until the cycle in which `*_req_ready` is high. The requester must hold its lookup inputs steady while `*_lk_stall` is high. The response channel has no ready signal: a `*_rsp_valid` pulse is accepted in any cycle after the request handshake. Only one refill per cache is outstanding at a time.

Top module: `utlb_pair`

## Requirements
- R1: A lookup that hits drives `*_lk_hit` high in the same cycle. `*_lk_ppn` and the 6-bit `*_lk_perm` carry exactly the values delivered when that entry was installed: bits 5:3 are kernel read/write/execute and bits 2:0 are user read/write/execute.
- R2: An entry matches when it is valid, its page number equals the lookup page number, and either its global bit is set or its ID equals the lookup ID.
- R3: A valid lookup that misses drives `*_lk_stall` high and `*_req_valid` high in the same cycle, with the lookup key on `*_req_vpn`/`*_req_asid`. The request stays high until `*_req_ready` is seen.
- R4: After the request handshake, `*_req_valid` stays low and the stall stays high until `*_rsp_valid`. The entry installed on that response makes the held lookup hit in the next cycle.
- R5: Installs fill slots 0, 1, …, N-1 and then wrap. Every accepted response advances the pointer, including a response squashed by a clear, so the (N+1)th install evicts the oldest slot.
- R6: The data cache holds 8 entries and the instruction cache holds 4. A refill into one leaves the other unchanged.
- R7: A joint-TLB write (`jtlb_wr`) with `jtlb_wr_keep` high leaves every entry of both caches intact.
- R8: A joint-TLB write with `jtlb_wr_keep` low invalidates every entry of both caches from the next cycle.
- R9: `utlb_inv` invalidates every entry of both caches from the next cycle, with no joint-TLB write.
- R10: A clear in the same cycle as a response install wins: the installed entry ends invalid.
- R11: After reset, every entry is invalid and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| jtlb_wr | input | 1 | Joint-TLB write strobe |
| jtlb_wr_keep | input | 1 | With `jtlb_wr`: keep the micro-TLB contents |
| utlb_inv | input | 1 | Explicit invalidate of both caches |
| d_lk_valid | input | 1 | Data lookup valid |
| d_lk_vpn | input | 19 | Data lookup virtual page number |
| d_lk_asid | input | 8 | Data lookup address-space ID |
| d_lk_hit | output | 1 | Data lookup hit |
| d_lk_stall | output | 1 | Data lookup miss, requester stalls |
| d_lk_ppn | output | 19 | Data physical page number |
| d_lk_perm | output | 6 | Data permissions (kernel rwx 5:3, user rwx 2:0) |
| d_req_valid | output | 1 | Data refill request valid |
| d_req_ready | input | 1 | Data refill request ready |
| d_req_vpn | output | 19 | Data refill page number |
| d_req_asid | output | 8 | Data refill ID |
| d_rsp_valid | input | 1 | Data refill response strobe |
| d_rsp_ppn | input | 19 | Data refill physical page |
| d_rsp_perm | input | 6 | Data refill permissions |
| d_rsp_global | input | 1 | Data refill global bit |
| i_lk_valid | input | 1 | Instruction lookup valid |
| i_lk_vpn | input | 19 | Instruction lookup page number |
| i_lk_asid | input | 8 | Instruction lookup ID |
| i_lk_hit | output | 1 | Instruction lookup hit |
| i_lk_stall | output | 1 | Instruction lookup miss |
| i_lk_ppn | output | 19 | Instruction physical page number |
| i_lk_perm | output | 6 | Instruction permissions |
| i_req_valid | output | 1 | Instruction refill request valid |
| i_req_ready | input | 1 | Instruction refill request ready |
| i_req_vpn | output | 19 | Instruction refill page number |
| i_req_asid | output | 8 | Instruction refill ID |
| i_rsp_valid | input | 1 | Instruction refill response strobe |
| i_rsp_ppn | input | 19 | Instruction refill physical page |
| i_rsp_perm | input | 6 | Instruction refill permissions |
| i_rsp_global | input | 1 | Instruction refill global bit |

## Verification
Hit, stall and request outputs are combinational in the lookup. The bench drives each lookup on a falling edge and samples 1 ns later, in the same cycle. An install becomes visible one edge after the response pulse, so the bench drops the pulse on the next falling edge and checks the hit there. Clears act on the edge that samples the strobe, and the following lookups see them. A reference model in the bench tracks slots, the round-robin pointer and clears, and supplies every expected hit, miss and payload.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
  localparam int PERM_W = 6;
  typedef enum logic {RF_IDLE, RF_WAIT} rf_state_t;
endpackage

// File: rtl/utlb_match.sv
module utlb_match #(
  parameter int N      = 8,
  parameter int VPN_W  = 19,
  parameter int ASID_W = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]      ent_v,
  input  logic [N-1:0]      ent_g,
  input  logic [VPN_W-1:0]  ent_vpn  [N],
  input  logic [ASID_W-1:0] ent_asid [N],
  input  logic [VPN_W-1:0]  key_vpn,
  input  logic [ASID_W-1:0] key_asid,
  output logic              any_hit,
  output logic [IDX_W-1:0]  hit_idx
);
  logic [N-1:0] hit_vec;

  for (genvar k = 0; k < N; k++) begin : g_cmp
    assign hit_vec[k] = ent_v[k] && (ent_vpn[k] == key_vpn) &&
                        (ent_g[k] || (ent_asid[k] == key_asid));
  end

  assign any_hit = |hit_vec;

  // lowest matching slot wins when several match
  always_comb begin
    hit_idx = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (hit_vec[k]) hit_idx = IDX_W'(k);
    end
  end
endmodule

// File: rtl/utlb_victim.sv
module utlb_victim #(
  parameter int N      = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  if (N == 1) begin : g_single
    assign ptr = '0;
  end else begin : g_ring
    logic [IDX_W-1:0] ptr_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ptr_q <= '0;
      else if (adv) begin
        if (ptr_q == IDX_W'(N - 1)) ptr_q <= '0;
        else                        ptr_q <= ptr_q + 1'b1;
      end
    end
    assign ptr = ptr_q;
  end
endmodule

// File: rtl/utlb_unit.sv
module utlb_unit
  import utlb_pkg::*;
#(
  parameter int N      = 8,
  parameter int VPN_W  = 19,
  parameter int ASID_W = 8,
  parameter int PPN_W  = 19,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              lk_valid,
  input  logic [VPN_W-1:0]  lk_vpn,
  input  logic [ASID_W-1:0] lk_asid,
  output logic              lk_hit,
  output logic              lk_stall,
  output logic [PPN_W-1:0]  lk_ppn,
  output logic [PERM_W-1:0] lk_perm,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [VPN_W-1:0]  req_vpn,
  output logic [ASID_W-1:0] req_asid,
  input  logic              rsp_valid,
  input  logic [PPN_W-1:0]  rsp_ppn,
  input  logic [PERM_W-1:0] rsp_perm,
  input  logic              rsp_global
);
  logic [N-1:0]      ent_v;
  logic [N-1:0]      ent_g;
  logic [VPN_W-1:0]  ent_vpn  [N];
  logic [ASID_W-1:0] ent_asid [N];
  logic [PPN_W-1:0]  ent_ppn  [N];
  logic [PERM_W-1:0] ent_perm [N];

  logic              any_hit;
  logic [IDX_W-1:0]  hit_idx;
  logic [IDX_W-1:0]  vic_ptr;
  logic              install;
  rf_state_t         fsm_q;
  logic [VPN_W-1:0]  key_vpn_q;
  logic [ASID_W-1:0] key_asid_q;

  utlb_match #(.N(N), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_match (
    .ent_v(ent_v), .ent_g(ent_g), .ent_vpn(ent_vpn), .ent_asid(ent_asid),
    .key_vpn(lk_vpn), .key_asid(lk_asid),
    .any_hit(any_hit), .hit_idx(hit_idx)
  );

  utlb_victim #(.N(N)) u_victim (
    .clk(clk), .rst_n(rst_n), .adv(install), .ptr(vic_ptr)
  );

  assign lk_hit    = lk_valid && any_hit;
  assign lk_stall  = lk_valid && !any_hit;
  assign lk_ppn    = ent_ppn[hit_idx];
  assign lk_perm   = ent_perm[hit_idx];
  assign req_valid = (fsm_q == RF_IDLE) && lk_valid && !any_hit;
  assign req_vpn   = lk_vpn;
  assign req_asid  = lk_asid;
  assign install   = (fsm_q == RF_WAIT) && rsp_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsm_q      <= RF_IDLE;
      key_vpn_q  <= '0;
      key_asid_q <= '0;
    end else begin
      case (fsm_q)
        RF_IDLE: if (req_valid && req_ready) begin
          fsm_q      <= RF_WAIT;
          key_vpn_q  <= lk_vpn;
          key_asid_q <= lk_asid;
        end
        RF_WAIT: if (rsp_valid) fsm_q <= RF_IDLE;
        default: fsm_q <= RF_IDLE;
      endcase
    end
  end

  // valid bits: a clear overrides a same-cycle install
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ent_v <= '0;
    else if (clr)     ent_v <= '0;
    else if (install) ent_v[vic_ptr] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (install) begin
      ent_vpn[vic_ptr]  <= key_vpn_q;
      ent_asid[vic_ptr] <= key_asid_q;
      ent_ppn[vic_ptr]  <= rsp_ppn;
      ent_perm[vic_ptr] <= rsp_perm;
      ent_g[vic_ptr]    <= rsp_global;
    end
  end

  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ent_v == '0)); // R8
  AST_SQUASHED_INSTALL: assert property (@(posedge clk) disable iff (!rst_n)
    (install && clr) |=> !lk_hit); // R10
  AST_INSTALL_HITS: assert property (@(posedge clk) disable iff (!rst_n)
    (install && !clr) |=> (!(lk_valid && $stable(lk_vpn) && $stable(lk_asid)) || lk_hit)); // R4
  AST_HIT_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_hit && !clr && !install) |=> (!(lk_valid && $stable(lk_vpn) && $stable(lk_asid)) || lk_hit)); // R7
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (!(lk_valid && $stable(lk_vpn) && $stable(lk_asid)) || req_valid)); // R3
endmodule

// File: rtl/utlb_pair.sv
module utlb_pair
  import utlb_pkg::*;
#(
  parameter int D_ENTRIES = 8,
  parameter int I_ENTRIES = 4,
  parameter int VPN_W     = 19,
  parameter int ASID_W    = 8,
  parameter int PPN_W     = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              jtlb_wr,
  input  logic              jtlb_wr_keep,
  input  logic              utlb_inv,
  input  logic              d_lk_valid,
  input  logic [VPN_W-1:0]  d_lk_vpn,
  input  logic [ASID_W-1:0] d_lk_asid,
  output logic              d_lk_hit,
  output logic              d_lk_stall,
  output logic [PPN_W-1:0]  d_lk_ppn,
  output logic [PERM_W-1:0] d_lk_perm,
  output logic              d_req_valid,
  input  logic              d_req_ready,
  output logic [VPN_W-1:0]  d_req_vpn,
  output logic [ASID_W-1:0] d_req_asid,
  input  logic              d_rsp_valid,
  input  logic [PPN_W-1:0]  d_rsp_ppn,
  input  logic [PERM_W-1:0] d_rsp_perm,
  input  logic              d_rsp_global,
  input  logic              i_lk_valid,
  input  logic [VPN_W-1:0]  i_lk_vpn,
  input  logic [ASID_W-1:0] i_lk_asid,
  output logic              i_lk_hit,
  output logic              i_lk_stall,
  output logic [PPN_W-1:0]  i_lk_ppn,
  output logic [PERM_W-1:0] i_lk_perm,
  output logic              i_req_valid,
  input  logic              i_req_ready,
  output logic [VPN_W-1:0]  i_req_vpn,
  output logic [ASID_W-1:0] i_req_asid,
  input  logic              i_rsp_valid,
  input  logic [PPN_W-1:0]  i_rsp_ppn,
  input  logic [PERM_W-1:0] i_rsp_perm,
  input  logic              i_rsp_global
);
  logic clr_all;

  // a write made with the keep flag leaves both caches alone
  assign clr_all = (jtlb_wr && !jtlb_wr_keep) || utlb_inv;

  utlb_unit #(.N(D_ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PPN_W(PPN_W)) u_data (
    .clk(clk), .rst_n(rst_n), .clr(clr_all),
    .lk_valid(d_lk_valid), .lk_vpn(d_lk_vpn), .lk_asid(d_lk_asid),
    .lk_hit(d_lk_hit), .lk_stall(d_lk_stall), .lk_ppn(d_lk_ppn), .lk_perm(d_lk_perm),
    .req_valid(d_req_valid), .req_ready(d_req_ready), .req_vpn(d_req_vpn), .req_asid(d_req_asid),
    .rsp_valid(d_rsp_valid), .rsp_ppn(d_rsp_ppn), .rsp_perm(d_rsp_perm), .rsp_global(d_rsp_global)
  );

  utlb_unit #(.N(I_ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PPN_W(PPN_W)) u_inst (
    .clk(clk), .rst_n(rst_n), .clr(clr_all),
    .lk_valid(i_lk_valid), .lk_vpn(i_lk_vpn), .lk_asid(i_lk_asid),
    .lk_hit(i_lk_hit), .lk_stall(i_lk_stall), .lk_ppn(i_lk_ppn), .lk_perm(i_lk_perm),
    .req_valid(i_req_valid), .req_ready(i_req_ready), .req_vpn(i_req_vpn), .req_asid(i_req_asid),
    .rsp_valid(i_rsp_valid), .rsp_ppn(i_rsp_ppn), .rsp_perm(i_rsp_perm), .rsp_global(i_rsp_global)
  );

  AST_INV_EMPTIES_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
    utlb_inv |=> (!d_lk_hit && !i_lk_hit)); // R9
  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!d_lk_hit && !i_lk_hit)); // R11
endmodule

// File: tb/utlb_pair_tb.sv
`timescale 1ns/1ps
module utlb_pair_tb_top;
  localparam int VW = 19;
  localparam int AW = 8;
  localparam int PW = 19;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic jtlb_wr = 1'b0, jtlb_wr_keep = 1'b0, utlb_inv = 1'b0;

  logic          lkv [2];
  logic [VW-1:0] lkvpn [2];
  logic [AW-1:0] lkasid [2];
  logic          hit [2];
  logic          stall [2];
  logic [PW-1:0] ppn [2];
  logic [5:0]    perm [2];
  logic          reqv [2];
  logic          rqready [2];
  logic [VW-1:0] reqvpn [2];
  logic [AW-1:0] reqasid [2];
  logic          rspv [2];
  logic [PW-1:0] rspppn [2];
  logic [5:0]    rspperm [2];
  logic          rspg [2];

  int total = 0;
  int bad = 0;

  bit m_v [2][8];
  bit m_g [2][8];
  int m_vpn [2][8];
  int m_asid [2][8];
  int m_ptr [2];

  always #5 clk = ~clk;

  utlb_pair dut_i (
    .clk(clk), .rst_n(rst_n), .jtlb_wr(jtlb_wr), .jtlb_wr_keep(jtlb_wr_keep), .utlb_inv(utlb_inv),
    .d_lk_valid(lkv[0]), .d_lk_vpn(lkvpn[0]), .d_lk_asid(lkasid[0]),
    .d_lk_hit(hit[0]), .d_lk_stall(stall[0]), .d_lk_ppn(ppn[0]), .d_lk_perm(perm[0]),
    .d_req_valid(reqv[0]), .d_req_ready(rqready[0]), .d_req_vpn(reqvpn[0]), .d_req_asid(reqasid[0]),
    .d_rsp_valid(rspv[0]), .d_rsp_ppn(rspppn[0]), .d_rsp_perm(rspperm[0]), .d_rsp_global(rspg[0]),
    .i_lk_valid(lkv[1]), .i_lk_vpn(lkvpn[1]), .i_lk_asid(lkasid[1]),
    .i_lk_hit(hit[1]), .i_lk_stall(stall[1]), .i_lk_ppn(ppn[1]), .i_lk_perm(perm[1]),
    .i_req_valid(reqv[1]), .i_req_ready(rqready[1]), .i_req_vpn(reqvpn[1]), .i_req_asid(reqasid[1]),
    .i_rsp_valid(rspv[1]), .i_rsp_ppn(rspppn[1]), .i_rsp_perm(rspperm[1]), .i_rsp_global(rspg[1])
  );

  function automatic int f_ppn(int vpn);
    return (vpn * 7 + 3) % (1 << PW);
  endfunction
  function automatic int f_perm(int vpn);
    return (vpn * 5 + 1) % 64;
  endfunction
  function automatic bit f_glob(int vpn);
    return (vpn % 5) == 4;
  endfunction
  function automatic int depth(int s);
    return (s == 0) ? 8 : 4;
  endfunction
  function automatic int m_find(int s, int vpn, int asid);
    for (int k = 0; k < depth(s); k++)
      if (m_v[s][k] && m_vpn[s][k] == vpn && (m_g[s][k] || m_asid[s][k] == asid)) return k;
    return -1;
  endfunction

  task automatic m_install(int s, int vpn, int asid);
    m_v[s][m_ptr[s]] = 1'b1;
    m_vpn[s][m_ptr[s]] = vpn;
    m_asid[s][m_ptr[s]] = asid;
    m_g[s][m_ptr[s]] = f_glob(vpn);
    m_ptr[s] = (m_ptr[s] + 1) % depth(s);
  endtask

  task automatic m_clear();
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 8; k++) m_v[s][k] = 1'b0;
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic clear_op(bit wr, bit keep, bit inv);
    @(negedge clk);
    jtlb_wr = wr; jtlb_wr_keep = keep; utlb_inv = inv;
    @(negedge clk);
    jtlb_wr = 1'b0; jtlb_wr_keep = 1'b0; utlb_inv = 1'b0;
    if ((wr && !keep) || inv) m_clear();
  endtask

  task automatic access(int s, int vpn, int asid, bit squash, string tag);
    int idx;
    bit sq;
    sq = squash;
    @(negedge clk);
    lkv[s] = 1'b1; lkvpn[s] = VW'(vpn); lkasid[s] = AW'(asid);
    #1;
    idx = m_find(s, vpn, asid);
    chk(tag, 32'(hit[s]), (idx >= 0) ? 1 : 0);
    chk("R3 stall", 32'(stall[s]), (idx < 0) ? 1 : 0);
    if (idx >= 0) begin
      chk("R1 ppn", 32'(ppn[s]), f_ppn(vpn));
      chk("R1 perm", 32'(perm[s]), f_perm(vpn));
    end else begin
      for (int t = 0; t < 3; t++) begin
        chk("R3 req", 32'(reqv[s]), 1);
        chk("R3 key", 32'({reqasid[s], reqvpn[s]}), 32'({AW'(asid), VW'(vpn)}));
        @(negedge clk); #1;
        chk("R3 hold", 32'(reqv[s]), 1);
        rqready[s] = 1'b1;
        @(negedge clk);
        rqready[s] = 1'b0;
        #1;
        chk("R4 quiet", 32'(reqv[s]), 0);
        chk("R4 stall", 32'(stall[s]), 1);
        rspv[s] = 1'b1; rspppn[s] = PW'(f_ppn(vpn)); rspperm[s] = 6'(f_perm(vpn));
        rspg[s] = f_glob(vpn);
        if (sq) utlb_inv = 1'b1;
        @(negedge clk);
        rspv[s] = 1'b0; utlb_inv = 1'b0;
        m_install(s, vpn, asid);
        if (sq) m_clear();
        #1;
        if (sq) begin
          chk("R10 squashed", 32'(hit[s]), 0);
          sq = 1'b0;
        end else begin
          chk("R4 installed", 32'(hit[s]), 1);
          chk("R1 ppn", 32'(ppn[s]), f_ppn(vpn));
          chk("R1 perm", 32'(perm[s]), f_perm(vpn));
          break;
        end
      end
    end
    lkv[s] = 1'b0;
  endtask

  task automatic finish_up();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(20240611);
    for (int s = 0; s < 2; s++) begin
      lkv[s] = 0; lkvpn[s] = 0; lkasid[s] = 0; rqready[s] = 0;
      rspv[s] = 0; rspppn[s] = 0; rspperm[s] = 0; rspg[s] = 0; m_ptr[s] = 0;
    end
    m_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    for (int s = 0; s < 2; s++) begin
      chk("R11 hit", 32'(hit[s]), 0);
      chk("R11 req", 32'(reqv[s]), 0);
    end
    access(0, 10, 1, 0, "R11 first miss");
    access(0, 10, 1, 0, "R1 hit");
    // R2: ID match versus global skip
    access(0, 11, 1, 0, "R2");
    access(0, 11, 2, 0, "R2 other id");
    access(0, 14, 1, 0, "R2 global install");
    access(0, 14, 3, 0, "R2 global hit");
    // R6: caches are independent
    access(1, 10, 1, 0, "R6 other cache");
    // R7: keep write
    clear_op(1, 1, 0);
    access(0, 10, 1, 0, "R7 data kept");
    access(1, 10, 1, 0, "R7 inst kept");
    // R8: flushing write
    clear_op(1, 0, 0);
    access(0, 10, 1, 0, "R8 data cleared");
    access(1, 10, 1, 0, "R8 inst cleared");
    // R9: explicit invalidate
    clear_op(0, 0, 1);
    access(0, 10, 1, 0, "R9 data cleared");
    access(1, 10, 1, 0, "R9 inst cleared");
    // R10: clear against install
    access(0, 20, 1, 1, "R10");
    // R5: round-robin on the 4-entry cache
    clear_op(0, 0, 1);
    for (int v = 100; v < 105; v++) access(1, v, 1, 0, "R5 fill");
    access(1, 101, 1, 0, "R5 survivor");
    access(1, 100, 1, 0, "R5 evicted");
    // R6: data cache depth 8
    clear_op(0, 0, 1);
    for (int v = 0; v < 8; v++) access(0, 300 + v, 2, 0, "R6 fill");
    for (int v = 0; v < 8; v++) access(0, 300 + v, 2, 0, "R6 depth");
    // random mix
    for (int n = 0; n < 400; n++) begin
      int r;
      r = $urandom % 16;
      if (r == 0) clear_op($urandom % 2, $urandom % 2, ($urandom % 4) == 0);
      else access($urandom % 2, 200 + $urandom % 12, $urandom % 3, r == 1, "R2 random");
    end
    finish_up();
  end
endmodule